// File: doc/BRIEF.md
# Pushbutton Wake and Ship-Mode Controller

This block times presses of an active-low pushbutton and turns them into events. The button level is not watched all the time. It is sampled once per polling period. The number of consecutive low samples is the press length. Three programmable thresholds, counted in samples, mark a first short press, a second short press and a long press. Crossing any of them raises a one-cycle interrupt and sets a sticky status bit. Nothing else happens. Reporting is allowed by an enable input. While an adapter is charging, that enable is overridden and sampling moves to the slower temperature-check schedule.

The block also drives the system-rail enable in each power mode. In the active mode the rail is on. In shutdown the rail is off, however long the button is held. In ship mode the rail turns on after either of two exits:
- a press that lasts a programmable number of samples;
- at once, when the input supply becomes valid.

A supply exit becomes final only after the supply has stayed valid for a qualification time. If the supply drops before that time, the rail goes off again.

Two state machines do the work. The press machine has these states:
- `PS_IDLE`: button released.
- `PS_HELD`: counting, no threshold reached yet.
- `PS_W1`: first threshold passed.
- `PS_W2`: second threshold passed.
- `PS_LONG`: long threshold passed.

Its transitions are:
- release, taken on any high sample, to `PS_IDLE`;
- first-hit, `PS_IDLE`/`PS_HELD` to `PS_W1`;
- second-hit, `PS_W1` to `PS_W2`;
- long-hit, `PS_W2` to `PS_LONG`;
- disable, taken when sampling stops, to `PS_IDLE`.

The ship-exit machine has these states:
- `SX_ASLEEP`: rail off.
- `SX_VQUAL`: rail on, supply being qualified.
- `SX_AWAKE`: rail on, exit committed.

Its transitions are:
- supply-seen, `SX_ASLEEP` to `SX_VQUAL`;
- supply-lost, `SX_VQUAL` to `SX_ASLEEP`;
- qualified, `SX_VQUAL` to `SX_AWAKE`;
- button-exit, `SX_ASLEEP` to `SX_AWAKE`;
- leave-ship, taken when the mode is anything other than ship, to `SX_ASLEEP`.

Top module: `btn_wake_ctrl`

## Requirements
- R1: After reset, `irq` and all three status bits are 0, and `sys_en` is 0 while `pwr_mode` is ship.
- R2: While sampling is on, the button is sampled once every `POLL_PER` cycles. Sampling is on when `push_en`=1, `chg_active`=1 or the mode is ship. The press length is the count of consecutive low samples, and one high sample resets it to 0. A press shorter than `wake1_th` samples produces no event.
- R3: When the press length reaches `wake1_th`, `irq` pulses and `wake1_stat` (status bit 0) sets. No other output changes.
- R4: Events come in the fixed order first, second, long. At most one event fires per sample, and each fires once per press. A press held far past `long_th` gives exactly three `irq` pulses and sets `wake1_stat`, `wake2_stat` (bit 1) and `long_stat` (bit 2).
- R5: `irq` is high for one cycle per event. The status bits stay set until `stat_clr` is pulsed.
- R6: With `push_en`=0 and `chg_active`=0, presses raise no `irq` and set no status bit.
- R7: With `chg_active`=1, events are reported even when `push_en`=0, and the button is sampled once every `NTC_PER` cycles.
- R8: In ship mode (`pwr_mode`=2'b01), a press of at least `ship_th` samples turns `sys_en` on, and it stays on after release. A shorter press leaves `sys_en` at 0.
- R9: In shutdown (`pwr_mode`=2'b10 or 2'b11), `sys_en` is 0 for a press of any length.
- R10: In ship mode, `sys_en` rises one cycle after `vin_ok` rises, whatever the button state. If `vin_ok` falls before `VIN_QUAL` cycles, `sys_en` returns to 0. If `vin_ok` is held at least that long, `sys_en` stays on.
- R11: In the active mode (`pwr_mode`=2'b00), `sys_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Button level, low while pressed |
| vin_ok | input | 1 | Input supply valid |
| pwr_mode | input | 2 | 00 active, 01 ship, 10/11 shutdown |
| push_en | input | 1 | Enable for button event reporting and sampling |
| chg_active | input | 1 | Adapter present and charging; overrides `push_en` |
| wake1_th | input | CNT_W | First short-press threshold, in samples |
| wake2_th | input | CNT_W | Second short-press threshold, in samples |
| long_th | input | CNT_W | Long-press threshold, in samples |
| ship_th | input | CNT_W | Ship-mode wake press length, in samples |
| stat_clr | input | 1 | Clears the status bits |
| irq | output | 1 | One-cycle event pulse |
| wake1_stat | output | 1 | Sticky first-threshold status |
| wake2_stat | output | 1 | Sticky second-threshold status |
| long_stat | output | 1 | Sticky long-press status |
| sys_en | output | 1 | System rail enable |

## Verification
The bench builds the block with `POLL_PER`=4, `NTC_PER`=6 and `VIN_QUAL`=6, and drives thresholds of 2, 4 and 6 samples with a ship threshold of 5. With these short periods, holding the button for L times the period gives exactly L samples. Press lengths on either side of every threshold, a long hold past the long threshold, and both sampling schedules therefore fit in a few hundred cycles. Because `NTC_PER` differs from `POLL_PER`, a wrong schedule while charging shows up as the wrong set of status bits. The short `VIN_QUAL` lets one run cover both a supply pulse that drops before qualification and one that commits.

// File: rtl/btn_wake_pkg.sv
package btn_wake_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'b00,
        PM_SHIP   = 2'b01,
        PM_SHUT   = 2'b10
    } pwr_mode_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_HELD,
        PS_W1,
        PS_W2,
        PS_LONG
    } press_st_e;

    typedef enum logic [1:0] {
        SX_ASLEEP,
        SX_VQUAL,
        SX_AWAKE
    } ship_st_e;

    typedef struct packed {
        logic long_ev;
        logic w2_ev;
        logic w1_ev;
    } btn_ev_t;

endpackage

// File: rtl/btn_poll_timer.sv
module btn_poll_timer #(
    parameter int POLL_PER = 32,
    parameter int NTC_PER  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic tick
);
    localparam int MAXP = (POLL_PER > NTC_PER) ? POLL_PER : NTC_PER;
    localparam int TW   = $clog2(MAXP + 1);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] lim;

    assign lim  = slow ? TW'(NTC_PER - 1) : TW'(POLL_PER - 1);
    assign tick = run && (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/btn_press_fsm.sv
module btn_press_fsm
    import btn_wake_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             btn_n,
    input  logic             report_en,
    input  logic [CNT_W-1:0] th1,
    input  logic [CNT_W-1:0] th2,
    input  logic [CNT_W-1:0] thl,
    output btn_ev_t          ev,
    output logic [CNT_W-1:0] press_cnt
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    press_st_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_n, cnt_inc;

    assign cnt_inc   = (press_cnt == CMAX) ? press_cnt : press_cnt + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= PS_IDLE;
            press_cnt <= '0;
        end else begin
            state_q   <= state_n;
            press_cnt <= cnt_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        cnt_n   = press_cnt;
        if (!run) begin
            state_n = PS_IDLE;
            cnt_n   = '0;
        end else if (tick) begin
            if (btn_n) begin
                state_n = PS_IDLE;
                cnt_n   = '0;
            end else begin
                cnt_n = cnt_inc;
                unique case (state_q)
                    PS_IDLE, PS_HELD: state_n = (cnt_inc >= th1) ? PS_W1 : PS_HELD;
                    PS_W1:            if (cnt_inc >= th2) state_n = PS_W2;
                    PS_W2:            if (cnt_inc >= thl) state_n = PS_LONG;
                    PS_LONG:          state_n = PS_LONG;
                    default:          state_n = PS_IDLE;
                endcase
            end
        end
    end

    // Outputs: one event per threshold crossing
    always_comb begin
        ev         = '0;
        ev.w1_ev   = report_en && (state_n == PS_W1)   && (state_q != PS_W1);
        ev.w2_ev   = report_en && (state_n == PS_W2)   && (state_q != PS_W2);
        ev.long_ev = report_en && (state_n == PS_LONG) && (state_q != PS_LONG);
    end
endmodule

// File: rtl/ship_exit_fsm.sv
module ship_exit_fsm
    import btn_wake_pkg::*;
#(
    parameter int VIN_QUAL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_ship,
    input  logic vin_ok,
    input  logic btn_hit,
    output logic awake
);
    localparam int QW = $clog2(VIN_QUAL + 1);

    ship_st_e      state_q, state_n;
    logic [QW-1:0] qcnt_q, qcnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SX_ASLEEP;
            qcnt_q  <= '0;
        end else begin
            state_q <= state_n;
            qcnt_q  <= qcnt_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        qcnt_n  = qcnt_q;
        if (!in_ship) begin
            state_n = SX_ASLEEP;
            qcnt_n  = '0;
        end else begin
            unique case (state_q)
                SX_ASLEEP: begin
                    qcnt_n = '0;
                    if (vin_ok)       state_n = SX_VQUAL;
                    else if (btn_hit) state_n = SX_AWAKE;
                end
                SX_VQUAL: begin
                    if (!vin_ok)                            state_n = SX_ASLEEP;
                    else if (qcnt_q >= QW'(VIN_QUAL - 1))   state_n = SX_AWAKE;
                    else                                    qcnt_n  = qcnt_q + 1'b1;
                end
                SX_AWAKE: state_n = SX_AWAKE;
                default:  state_n = SX_ASLEEP;
            endcase
        end
    end

    // Outputs
    always_comb begin
        awake = (state_q != SX_ASLEEP);
    end
endmodule

// File: rtl/btn_wake_ctrl.sv
module btn_wake_ctrl
    import btn_wake_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int POLL_PER = 32,
    parameter int NTC_PER  = 64,
    parameter int VIN_QUAL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_n,
    input  logic             vin_ok,
    input  logic [1:0]       pwr_mode,
    input  logic             push_en,
    input  logic             chg_active,
    input  logic [CNT_W-1:0] wake1_th,
    input  logic [CNT_W-1:0] wake2_th,
    input  logic [CNT_W-1:0] long_th,
    input  logic [CNT_W-1:0] ship_th,
    input  logic             stat_clr,
    output logic             irq,
    output logic             wake1_stat,
    output logic             wake2_stat,
    output logic             long_stat,
    output logic             sys_en
);
    logic             in_ship, in_active, run, report_en, tick, ship_hit, awake;
    btn_ev_t          ev;
    logic [2:0]       stat_q;
    logic [CNT_W-1:0] press_cnt;

    assign in_ship   = (pwr_mode == PM_SHIP);
    assign in_active = (pwr_mode == PM_ACTIVE);
    assign report_en = push_en || chg_active;
    assign run       = report_en || in_ship;

    btn_poll_timer #(.POLL_PER(POLL_PER), .NTC_PER(NTC_PER)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .slow  (chg_active),
        .tick  (tick)
    );

    btn_press_fsm #(.CNT_W(CNT_W)) u_press (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .btn_n     (btn_n),
        .report_en (report_en),
        .th1       (wake1_th),
        .th2       (wake2_th),
        .thl       (long_th),
        .ev        (ev),
        .press_cnt (press_cnt)
    );

    assign ship_hit = in_ship && (press_cnt != '0) && (press_cnt >= ship_th);

    ship_exit_fsm #(.VIN_QUAL(VIN_QUAL)) u_ship (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_ship (in_ship),
        .vin_ok  (vin_ok),
        .btn_hit (ship_hit),
        .awake   (awake)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq    <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~{3{stat_clr}}) | ev;
            irq    <= |ev;
        end
    end

    assign wake1_stat = stat_q[0];
    assign wake2_stat = stat_q[1];
    assign long_stat  = stat_q[2];
    assign sys_en     = in_active || (in_ship && awake);
endmodule

// File: rtl/btn_wake_ctrl_chk.sv
module btn_wake_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pwr_mode,
    input logic       push_en,
    input logic       chg_active,
    input logic       vin_ok,
    input logic       stat_clr,
    input logic       irq,
    input logic       wake1_stat,
    input logic       sys_en,
    input logic [2:0] ev
);
    p_shut_rail_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode[1] |-> !sys_en);

    p_active_rail_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'b00) |-> sys_en);

    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_w1_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake1_stat && !stat_clr) |=> wake1_stat);

    p_quiet_when_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_en && !chg_active) |=> !irq);

    p_vin_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'b01 && vin_ok) |=> (sys_en || pwr_mode != 2'b01));

    p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev));

    p_stat_with_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake1_stat) |-> irq);
endmodule

bind btn_wake_ctrl btn_wake_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_mode   (pwr_mode),
    .push_en    (push_en),
    .chg_active (chg_active),
    .vin_ok     (vin_ok),
    .stat_clr   (stat_clr),
    .irq        (irq),
    .wake1_stat (wake1_stat),
    .sys_en     (sys_en),
    .ev         (ev)
);

// File: tb/btn_wake_ctrl_test.sv
module btn_wake_ctrl_test;
    localparam int CNT_W = 8;
    localparam int PP    = 4;
    localparam int NP    = 6;
    localparam int VQ    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1, vin_ok = 1'b0, push_en = 1'b0, chg_active = 1'b0, stat_clr = 1'b0;
    logic [1:0] pwr_mode = 2'b01;
    logic [CNT_W-1:0] wake1_th = 8'd2, wake2_th = 8'd4, long_th = 8'd6, ship_th = 8'd5;
    logic irq, wake1_stat, wake2_stat, long_stat, sys_en;

    int checks = 0, fails = 0, irq_seen = 0;
    logic counting = 1'b0;

    always #2.5 clk = ~clk;

    btn_wake_ctrl #(.CNT_W(CNT_W), .POLL_PER(PP), .NTC_PER(NP), .VIN_QUAL(VQ)) uut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .vin_ok(vin_ok), .pwr_mode(pwr_mode),
        .push_en(push_en), .chg_active(chg_active), .wake1_th(wake1_th), .wake2_th(wake2_th),
        .long_th(long_th), .ship_th(ship_th), .stat_clr(stat_clr), .irq(irq),
        .wake1_stat(wake1_stat), .wake2_stat(wake2_stat), .long_stat(long_stat), .sys_en(sys_en)
    );

    always @(negedge clk) if (counting && irq) irq_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // {mode[19:18], en[17], chg[16], samples[15:8], stat{long,w2,w1}[7:5], irqs[4:1], sys[0]}
    localparam logic [19:0] VEC [10] = '{
        {2'd0, 1'b1, 1'b0, 8'd1, 3'b000, 4'd0, 1'b1},  // R2 below first threshold
        {2'd0, 1'b1, 1'b0, 8'd2, 3'b001, 4'd1, 1'b1},  // R3 first threshold
        {2'd0, 1'b1, 1'b0, 8'd5, 3'b011, 4'd2, 1'b1},  // R4 two events
        {2'd0, 1'b1, 1'b0, 8'd9, 3'b111, 4'd3, 1'b1},  // R4 long hold, once each
        {2'd0, 1'b0, 1'b0, 8'd9, 3'b000, 4'd0, 1'b1},  // R6 disabled
        {2'd0, 1'b0, 1'b1, 8'd4, 3'b011, 4'd2, 1'b1},  // R7 charging override
        {2'd1, 1'b0, 1'b0, 8'd4, 3'b000, 4'd0, 1'b0},  // R8 short ship press
        {2'd1, 1'b0, 1'b0, 8'd5, 3'b000, 4'd0, 1'b1},  // R8 ship wake press
        {2'd2, 1'b1, 1'b0, 8'd9, 3'b111, 4'd3, 1'b0},  // R9 shutdown
        {2'd1, 1'b1, 1'b0, 8'd6, 3'b111, 4'd3, 1'b1}   // R8 ship with events
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [19:0] v;
        int per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", int'(irq), 0);
        chk("R1 status", int'({long_stat, wake2_stat, wake1_stat}), 0);
        chk("R1 sys_en", int'(sys_en), 0);

        for (int i = 0; i < 10; i++) begin
            v = VEC[i];
            btn_n = 1'b1; pwr_mode = 2'b00; push_en = 1'b0; chg_active = 1'b0;
            repeat (2) @(negedge clk);
            pwr_mode = v[19:18]; push_en = v[17]; chg_active = v[16];
            stat_clr = 1'b1;
            @(negedge clk);
            stat_clr = 1'b0;
            repeat (2 * NP) @(negedge clk);
            per = v[16] ? NP : PP;
            irq_seen = 0;
            counting = 1'b1;
            btn_n = 1'b0;
            repeat (int'(v[15:8]) * per) @(negedge clk);
            btn_n = 1'b1;
            repeat (per + 3) @(negedge clk);
            counting = 1'b0;
            chk($sformatf("R3/R4 vec%0d status", i), int'({long_stat, wake2_stat, wake1_stat}), int'(v[7:5]));
            chk($sformatf("R5 vec%0d irq pulses", i), irq_seen, int'(v[4:1]));
            chk($sformatf("R8/R9/R11 vec%0d sys_en", i), int'(sys_en), int'(v[0]));
        end

        // R5: status held, then cleared by strobe
        repeat (5) @(negedge clk);
        chk("R5 held", int'({long_stat, wake2_stat, wake1_stat}), 7);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        chk("R5 cleared", int'({long_stat, wake2_stat, wake1_stat}), 0);

        // R10: supply exit from ship
        pwr_mode = 2'b00; push_en = 1'b0;
        repeat (2) @(negedge clk);
        pwr_mode = 2'b01;
        repeat (3) @(negedge clk);
        chk("R10 asleep", int'(sys_en), 0);
        btn_n = 1'b0;
        vin_ok = 1'b1;
        @(negedge clk);
        chk("R10 immediate", int'(sys_en), 1);
        @(negedge clk);
        btn_n = 1'b1;
        vin_ok = 1'b0;
        @(negedge clk);
        chk("R10 dropped early", int'(sys_en), 0);
        repeat (3 * PP) @(negedge clk);
        vin_ok = 1'b1;
        repeat (VQ + 4) @(negedge clk);
        vin_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 committed", int'(sys_en), 1);
        pwr_mode = 2'b00;
        @(negedge clk);
        chk("R11 active", int'(sys_en), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule